// File: doc/BRIEF.md
# I2C Bit-Level Command Master

This block turns short host commands into the SCL and SDA edge sequences of an I2C bus, taking the place of a software routine that would otherwise toggle two output bits one store at a time. A 12-bit host offers one of three commands: a start condition, a stop condition, or a byte write. The block drives both open-drain lines through active-high pull-down enables, so a line reads high whenever its enable is low and an external pull-up holds it there.

A byte write takes a 12-bit host word and keeps only its low eight bits. Those bits go out most significant first. A ninth clock follows with SDA released, and the level the addressed device leaves on SDA during that clock is held on `nack`. Every bit is built from three phases of equal length: SDA set with SCL low, SCL released high, and SCL pulled low again. The phase length is a fixed number of system clock cycles, set by a parameter. SCL is never read back, so a device that holds SCL low does not slow the sequence.

Command intake follows valid/ready rules without queueing. `busy` low means ready. A strobe is taken only in a cycle where `busy` is low. A strobe offered while `busy` is high is dropped and not held, so the host must wait for `done` or for `busy` low before it issues the next command. Between commands both lines keep the level the last phase left on them, which lets a start, several writes and a stop form one transfer.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `busy`, `done` and `nack` are all 0, so both lines are released.
- R2: A strobe seen while `busy` is 0 starts its command, and `busy` reads 1 in the next cycle. If several strobes arrive in the same cycle, start wins over stop, and stop wins over write.
- R3: A start has two phases. In the first, SCL and SDA are both released (`scl_oe`=0, `sda_oe`=0). In the second, SCL stays released and SDA is pulled low (`sda_oe`=1).
- R4: A stop has two phases. In the first, SCL is released and SDA is pulled low. In the second, both lines are released.
- R5: A write sends `wr_data[7:0]` starting at bit 7 and ignores `wr_data[11:8]`. Each bit takes three phases: `sda_oe` = NOT bit with `scl_oe`=1, then `scl_oe`=0, then `scl_oe`=1. `sda_oe` keeps the same value through all three phases.
- R6: After the eighth data bit, a ninth three-phase clock runs with `sda_oe`=0.
- R7: `nack` takes the `sda_in` level sampled in the last cycle of the SCL-high phase of the ninth clock. It keeps that value until the next write samples again. Start and stop leave it unchanged.
- R8: Every phase lasts exactly PHASE_CYCLES clock cycles. `busy` stays 1 for 2·PHASE_CYCLES cycles for a start or a stop, and for 27·PHASE_CYCLES cycles for a write.
- R9: `done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 again after a command.
- R10: Any strobe that arrives while `busy` is 1 has no effect on the line sequence in progress, and no further command starts afterwards.
- R11: While no command runs, `scl_oe` and `sda_oe` keep the values of the last phase driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Strobe: issue a start condition |
| stop_req | input | 1 | Strobe: issue a stop condition |
| wr_req | input | 1 | Strobe: write the low byte of `wr_data` |
| wr_data | input | 12 | Host word; only bits 7..0 are sent |
| sda_in | input | 1 | Level sensed on the SDA line |
| busy | output | 1 | Command in progress; low means ready |
| done | output | 1 | One-cycle pulse when a command finishes |
| nack | output | 1 | SDA level captured on the acknowledge clock |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Writes use random 12-bit words, so random upper nibbles show whether bits 11..8 ever leak onto SDA. The all-ones and all-zeros bytes and alternating patterns separate a wrong bit order from a wrong bit polarity. Random runs of start, stop and write, issued back to back, show that the line levels carry over from one command to the next. They also show that a device driving the acknowledge low or leaving it high changes only `nack`. Strobes fired at random points inside a busy command, and several strobes fired in one idle cycle, check that late requests are dropped and that simultaneous requests are served in priority order.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_STOP  = 2'd2,
    SEQ_WRITE = 2'd3
  } seq_state_t;

  localparam int COND_PHASES = 2;
  localparam int BIT_PHASES  = 3;
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int PHASE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && !restart && (cnt == LAST);
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic             next_bit
);
  logic [WIDTH-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '1;
    else if (load)  sreg <= load_val;
    else if (shift) sreg <= {sreg[WIDTH-2:0], 1'b1};
  end

  // bit that becomes current after the next shift; ones fill in so the
  // acknowledge clock sees a released line
  assign next_bit = sreg[WIDTH-2];
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int HOST_W       = 12,
  parameter int BYTE_W       = 8,
  parameter int PHASE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              wr_req,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              sda_in,
  output logic              busy,
  output logic              done,
  output logic              nack,
  output logic              scl_oe,
  output logic              sda_oe
);
  import i2c_cmd_pkg::*;

  localparam int BIT_TOTAL = BYTE_W + 1;
  localparam int BCW       = $clog2(BIT_TOTAL + 1);
  localparam logic [BCW-1:0] ACK_IDX = BCW'(BYTE_W);

  seq_state_t     state;
  logic [1:0]     phase;
  logic [BCW-1:0] bit_idx;
  logic           tick, accept, ld_byte, sh_byte, nxt_bit;

  assign busy    = (state != SEQ_IDLE);
  assign accept  = !busy && (start_req || stop_req || wr_req);
  assign ld_byte = accept && !start_req && !stop_req;
  assign sh_byte = (state == SEQ_WRITE) && tick && (phase == 2'd2) && (bit_idx != ACK_IDX);

  i2c_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy), .tick(tick)
  );

  i2c_byte_shifter #(.WIDTH(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld_byte), .load_val(wr_data[BYTE_W-1:0]),
    .shift(sh_byte), .next_bit(nxt_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      phase   <= 2'd0;
      bit_idx <= '0;
      done    <= 1'b0;
      nack    <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase   <= 2'd0;
        bit_idx <= '0;
        if (start_req) begin
          state  <= SEQ_START;
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
        end else if (stop_req) begin
          state  <= SEQ_STOP;
          scl_oe <= 1'b0;
          sda_oe <= 1'b1;
        end else begin
          state  <= SEQ_WRITE;
          scl_oe <= 1'b1;
          sda_oe <= !wr_data[BYTE_W-1];
        end
      end else if (tick) begin
        unique case (state)
          SEQ_START, SEQ_STOP: begin
            if (phase == 2'd0) begin
              phase  <= 2'd1;
              sda_oe <= (state == SEQ_START);
            end else begin
              state <= SEQ_IDLE;
              done  <= 1'b1;
            end
          end
          SEQ_WRITE: begin
            unique case (phase)
              2'd0: begin
                phase  <= 2'd1;
                scl_oe <= 1'b0;
              end
              2'd1: begin
                phase  <= 2'd2;
                scl_oe <= 1'b1;
                if (bit_idx == ACK_IDX) nack <= sda_in;
              end
              default: begin
                if (bit_idx == ACK_IDX) begin
                  state <= SEQ_IDLE;
                  done  <= 1'b1;
                end else begin
                  phase   <= 2'd0;
                  bit_idx <= bit_idx + 1'b1;
                  sda_oe  <= (bit_idx == ACK_IDX - 1'b1) ? 1'b0 : !nxt_bit;
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic stop_req,
  input logic wr_req,
  input logic busy,
  input logic done,
  input logic scl_oe,
  input logic sda_oe
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_lines_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req || stop_req || wr_req));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$past(done));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
  .wr_req(wr_req), .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, wr_req = 1'b0;
  logic [11:0] wr_data = '0;
  logic slave_low = 1'b0;
  logic sda_in;
  logic busy, done, nack, scl_oe, sda_oe;

  int checks = 0;
  int errors = 0;
  bit exp_nack = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_in = !sda_oe && !slave_low;

  i2c_cmd_master dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .wr_req(wr_req), .wr_data(wr_data), .sda_in(sda_in), .busy(busy),
    .done(done), .nack(nack), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {scl_oe, sda_oe} for phase k; op 0 start, 1 stop, 2 write
  function automatic logic [1:0] exp_lines(input int op, input logic [11:0] d, input int k);
    int b, p;
    logic bv;
    if (op == 0) return (k == 0) ? 2'b00 : 2'b01;
    if (op == 1) return (k == 0) ? 2'b01 : 2'b00;
    b  = k / 3;
    p  = k % 3;
    bv = (b < 8) ? d[7 - b] : 1'b1;
    return {(p != 1), !bv};
  endfunction

  task automatic run_cmd(input logic [2:0] strobes, input logic [11:0] d,
                         input bit slv, input int intf_at);
    int op, nph, total;
    logic [1:0] last;
    op    = strobes[2] ? 0 : (strobes[1] ? 1 : 2);
    nph   = (op == 2) ? 27 : 2;
    total = nph * P;
    @(negedge clk);
    {start_req, stop_req, wr_req} = strobes;
    wr_data   = d;
    slave_low = slv && (op == 2);
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      {start_req, stop_req, wr_req} = 3'b000;
      wr_data = 12'($urandom);
      if ((n - 1) % P == P / 2) begin
        last = exp_lines(op, d, (n - 1) / P);
        check(busy == 1'b1, "R8 busy", busy, 1);
        check(done == 1'b0, "R9 done low", done, 0);
        check({scl_oe, sda_oe} == last,
              (op == 0) ? "R3 start" : (op == 1) ? "R4 stop" : ((n - 1) / P >= 24) ? "R6 ack clock" : "R5 data",
              {scl_oe, sda_oe}, last);
      end
      if (n == intf_at) {start_req, stop_req, wr_req} = 3'($urandom_range(1, 7)); // R10
    end
    @(negedge clk);
    {start_req, stop_req, wr_req} = 3'b000;
    slave_low = 1'b0;
    if (op == 2) exp_nack = !slv;
    check(done == 1'b1 && busy == 1'b0, "R9 done pulse", {busy, done}, 1);
    check(nack == exp_nack, "R7 nack", nack, exp_nack);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 no late start", {busy, done}, 0);
    last = exp_lines(op, d, nph - 1);
    check({scl_oe, sda_oe} == last, "R11 hold", {scl_oe, sda_oe}, last);
  endtask

  initial begin
    #(5.0 * 190000);
    check(1'b0, "watchdog", 0, 1);
    if (!finished) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, busy, done, nack} == 5'b0, "R1 reset", {scl_oe, sda_oe, busy, done, nack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({scl_oe, sda_oe, busy, done, nack} == 5'b0, "R1 after reset", {scl_oe, sda_oe, busy, done, nack}, 0);
    // directed corners
    run_cmd(3'b100, 12'h000, 1'b0, 0);            // R3
    run_cmd(3'b001, 12'hFFF, 1'b1, 0);            // R5 all ones, ack low -> nack 0
    run_cmd(3'b001, 12'hF00, 1'b0, 0);            // R5 upper nibble ignored, nack 1
    run_cmd(3'b001, 12'h0A5, 1'b1, 5);            // R10 strobe mid write
    run_cmd(3'b100, 12'h000, 1'b0, 0);            // R7 nack kept over start
    run_cmd(3'b111, 12'h05A, 1'b0, 0);            // R2 start wins
    run_cmd(3'b011, 12'h05A, 1'b0, 0);            // R2 stop wins over write
    run_cmd(3'b010, 12'h000, 1'b0, 3);            // R4
    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [2:0] s;
      s = 3'b001 << $urandom_range(0, 2);
      run_cmd(s, 12'($urandom), 1'($urandom), ($urandom_range(0, 1) == 1) ? $urandom_range(1, 2 * P) : 0);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule